// File: doc/BRIEF.md
# Double-Buffered Raster Timing and Fetch Address Controller

This block drives the scan of a 512 x 342 grayscale raster. Free-running horizontal and vertical counters produce active-low sync pulses, a display-enable strobe and a byte address for the pixel fetch path. Each line is 64 bytes of frame memory. The fetch address is the base address of the displayed buffer, plus the line number times 64, plus the pixel column divided by eight.

Software draws into one of two frame buffers while the other is shown. It requests a swap with a single register write. The block exchanges which base pointer feeds the fetch address, and only on the clock where vertical blanking starts, so one frame never shows two buffers. A request made mid-frame stays pending until that point, and a status bit shows that it is waiting.

Two sticky event flags, one for the start of vertical blanking and one for each line end, feed one registered interrupt through separate enables. The current scan line can be read back, so software can judge whether a line it is about to write is being displayed.

Top module: `page_flip_raster`

## Requirements
- R1: A line lasts H_TOTAL clocks (704 by default) and a frame lasts V_TOTAL lines (370). `de` is high exactly for columns below H_ACTIVE (512) on lines below V_ACTIVE (342). All raster outputs are registered and appear one clock after the counter position they describe.
- R2: `hsync_n` is low for columns H_SYNC_START to H_SYNC_START+H_SYNC_LEN-1, and `vsync_n` is low for lines V_SYNC_START to V_SYNC_START+V_SYNC_LEN-1. Both windows lie inside blanking.
- R3: For an active pixel at line v and column h, `fetch_addr` = active base + (v << LINE_SHIFT) + (h >> PIX_SHIFT), with LINE_SHIFT=6 and PIX_SHIFT=3. During blanking, `fetch_addr` holds its last active value.
- R4: Host address 0 holds base A and address 1 holds base B (ADDR_W bits, read back zero-extended). Status bit 3 reads 0 while base A is displayed and 1 while base B is displayed. Reset selects base A.
- R5: Any write to host address 4 requests a swap. The swap takes effect on the clock edge that leaves the last column of the last active line. A request made at any other time waits for that edge. A request made on that exact edge is applied at once.
- R6: Status bit 2 is the pending-swap flag. A swap request sets it, and it clears on the edge where the swap takes effect.
- R7: Status bit 0 sets on the edge that starts vertical blanking, and status bit 1 sets at the end of every line. Both are sticky. Writing 1 to a bit at host address 3 clears it, writing 0 leaves it unchanged, and a set on the same edge wins over a clear.
- R8: Control register (host address 2) bit 0 enables the vertical-blank interrupt and bit 1 enables the line interrupt. `irq` is the registered OR of each status bit 0/1 ANDed with its enable. A disabled source never raises `irq`.
- R9: Host address 5 reads the current line counter. Read data is registered: `host_rdata` after an edge reflects `host_addr` and register state as they were before that edge. Unused addresses read 0.
- R10: Synchronous reset clears the counters, bases, control, status and read data. It drives `de`, `irq` and `fetch_addr` to 0 and both syncs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address for write and read |
| host_wdata | input | DATA_W | Register write data |
| host_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable for the active area |
| fetch_addr | output | ADDR_W | Frame-buffer byte address for the pixel fetch |

## Verification
A small raster (16x6 active in 24x10 total) lets many frames run. A bench model predicts every output and the read data on every clock. Directed swap requests are placed mid-frame, inside blanking and exactly on the retrace edge. These separate a swap that waits for retrace from one applied at once, and from one that wrongly slips a whole frame. Random writes to the base, control and status registers, interleaved with random reads, show apart the set-wins-over-clear rule, the effect of the enables on the interrupt, and a change of the displayed base taking effect at once versus a change of the hidden base having no visible effect.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [2:0] {
    REG_BASE_A = 3'd0,
    REG_BASE_B = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STAT   = 3'd3,
    REG_SWAP   = 3'd4,
    REG_LINE   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/pfr_timing.sv
module pfr_timing #(
  parameter int H_ACTIVE = 512,
  parameter int H_TOTAL = 704,
  parameter int H_SYNC_START = 536,
  parameter int H_SYNC_LEN = 64,
  parameter int V_ACTIVE = 342,
  parameter int V_TOTAL = 370,
  parameter int V_SYNC_START = 346,
  parameter int V_SYNC_LEN = 4,
  localparam int HB = $clog2(H_TOTAL),
  localparam int VB = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HB-1:0] hcnt,
  output logic [VB-1:0] vcnt,
  output logic          active,
  output logic          frame_evt,
  output logic          line_evt,
  output logic          de_q,
  output logic          hsync_n_q,
  output logic          vsync_n_q
);
  localparam logic [HB-1:0] H_LAST = HB'(H_TOTAL - 1);
  localparam logic [VB-1:0] V_LAST = VB'(V_TOTAL - 1);
  localparam logic [HB-1:0] H_ACT = HB'(H_ACTIVE);
  localparam logic [VB-1:0] V_ACT = VB'(V_ACTIVE);
  localparam logic [VB-1:0] V_ACT_LAST = VB'(V_ACTIVE - 1);
  localparam logic [HB-1:0] HS_LO = HB'(H_SYNC_START);
  localparam logic [HB-1:0] HS_HI = HB'(H_SYNC_START + H_SYNC_LEN);
  localparam logic [VB-1:0] VS_LO = VB'(V_SYNC_START);
  localparam logic [VB-1:0] VS_HI = VB'(V_SYNC_START + V_SYNC_LEN);

  assign active    = (hcnt < H_ACT) && (vcnt < V_ACT);
  assign line_evt  = (hcnt == H_LAST);
  assign frame_evt = line_evt && (vcnt == V_ACT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
      de_q <= 1'b0;
      hsync_n_q <= 1'b1;
      vsync_n_q <= 1'b1;
    end else begin
      if (line_evt) begin
        hcnt <= '0;
        vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      de_q <= active;
      hsync_n_q <= !((hcnt >= HS_LO) && (hcnt < HS_HI));
      vsync_n_q <= !((vcnt >= VS_LO) && (vcnt < VS_HI));
    end
  end

  p_hcnt_range_r1: assert property (@(posedge clk) disable iff (rst) hcnt <= H_LAST);
  p_vcnt_range_r1: assert property (@(posedge clk) disable iff (rst) vcnt <= V_LAST);
  p_hsync_blank_r2: assert property (@(posedge clk) disable iff (rst) !hsync_n_q |-> !de_q);
  p_vsync_blank_r2: assert property (@(posedge clk) disable iff (rst) !vsync_n_q |-> !de_q);
endmodule

// File: rtl/pfr_flip.sv
module pfr_flip #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              swap_req,
  input  logic              frame_evt,
  output logic [ADDR_W-1:0] base_a,
  output logic [ADDR_W-1:0] base_b,
  output logic [ADDR_W-1:0] shown_base,
  output logic              show_b,
  output logic              pending
);
  logic apply;
  assign apply = frame_evt && (pending || swap_req);
  assign shown_base = show_b ? base_b : base_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a <= '0;
      base_b <= '0;
      show_b <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (base_we[0]) base_a <= base_wdata;
      if (base_we[1]) base_b <= base_wdata;
      if (apply) begin
        show_b <= !show_b;
        pending <= 1'b0;
      end else if (swap_req) begin
        pending <= 1'b1;
      end
    end
  end

  p_swap_at_retrace_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(show_b) |-> $past(frame_evt));
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> ($past(frame_evt) && !$stable(show_b)));
  p_pend_set_r6: assert property (@(posedge clk) disable iff (rst)
    (swap_req && !frame_evt) |=> pending);
endmodule

// File: rtl/pfr_addr.sv
module pfr_addr #(
  parameter int ADDR_W = 24,
  parameter int HB = 10,
  parameter int VB = 9,
  parameter int LINE_SHIFT = 6,
  parameter int PIX_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [HB-1:0]     hcnt,
  input  logic [VB-1:0]     vcnt,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] line_off, pix_off;
  assign line_off = ADDR_W'(vcnt) << LINE_SHIFT;
  assign pix_off  = ADDR_W'(hcnt >> PIX_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (active) addr_q <= base + line_off + pix_off;
  end

  p_hold_blank_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> $stable(addr_q));
endmodule

// File: rtl/pfr_regs.sv
module pfr_regs
  import pfr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int VB = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [1:0]        wbits,
  input  logic              frame_evt,
  input  logic              line_evt,
  input  logic              pending,
  input  logic              show_b,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [VB-1:0]     vcnt,
  output logic [1:0]        base_we,
  output logic              swap_req,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_q
);
  logic [1:0] en_q, st_q, st_set, st_clr;
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  assign base_we[0] = we && (sel == REG_BASE_A);
  assign base_we[1] = we && (sel == REG_BASE_B);
  assign swap_req   = we && (sel == REG_SWAP);
  assign st_set     = {line_evt, frame_evt};
  assign st_clr     = (we && (sel == REG_STAT)) ? wbits : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= 1'b0;
      rdata <= '0;
    end else begin
      if (we && (sel == REG_CTRL)) en_q <= wbits;
      st_q  <= (st_q & ~st_clr) | st_set;
      irq_q <= |(st_q & en_q);
      case (sel)
        REG_BASE_A: rdata <= DATA_W'(base_a);
        REG_BASE_B: rdata <= DATA_W'(base_b);
        REG_CTRL:   rdata <= DATA_W'(en_q);
        REG_STAT:   rdata <= DATA_W'({show_b, pending, st_q});
        REG_LINE:   rdata <= DATA_W'(vcnt);
        default:    rdata <= '0;
      endcase
    end
  end

  p_sticky_vb_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q[0] && !st_clr[0]) |=> st_q[0]);
  p_sticky_ln_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q[1] && !st_clr[1]) |=> st_q[1]);
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q == 2'b00) |=> !irq_q);
endmodule

// File: rtl/page_flip_raster.sv
module page_flip_raster #(
  parameter int H_ACTIVE = 512,
  parameter int H_TOTAL = 704,
  parameter int H_SYNC_START = 536,
  parameter int H_SYNC_LEN = 64,
  parameter int V_ACTIVE = 342,
  parameter int V_TOTAL = 370,
  parameter int V_SYNC_START = 346,
  parameter int V_SYNC_LEN = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LINE_SHIFT = 6,
  parameter int PIX_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int HB = $clog2(H_TOTAL);
  localparam int VB = $clog2(V_TOTAL);

  logic [HB-1:0] hcnt;
  logic [VB-1:0] vcnt;
  logic active, frame_evt, line_evt, swap_req, show_b, pending;
  logic [1:0] base_we;
  logic [ADDR_W-1:0] base_a, base_b, shown_base;

  generate
    if (DATA_W > ADDR_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^host_wdata[DATA_W-1:ADDR_W];
    end
  endgenerate

  pfr_timing #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .H_SYNC_START(H_SYNC_START), .H_SYNC_LEN(H_SYNC_LEN),
    .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL), .V_SYNC_START(V_SYNC_START), .V_SYNC_LEN(V_SYNC_LEN)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .active(active),
    .frame_evt(frame_evt), .line_evt(line_evt),
    .de_q(de), .hsync_n_q(hsync_n), .vsync_n_q(vsync_n)
  );

  pfr_flip #(.ADDR_W(ADDR_W)) u_flip (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(host_wdata[ADDR_W-1:0]),
    .swap_req(swap_req), .frame_evt(frame_evt), .base_a(base_a), .base_b(base_b),
    .shown_base(shown_base), .show_b(show_b), .pending(pending)
  );

  pfr_addr #(
    .ADDR_W(ADDR_W), .HB(HB), .VB(VB), .LINE_SHIFT(LINE_SHIFT), .PIX_SHIFT(PIX_SHIFT)
  ) u_addr (
    .clk(clk), .rst(rst), .active(active), .hcnt(hcnt), .vcnt(vcnt),
    .base(shown_base), .addr_q(fetch_addr)
  );

  pfr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VB(VB)) u_regs (
    .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wbits(host_wdata[1:0]),
    .frame_evt(frame_evt), .line_evt(line_evt), .pending(pending), .show_b(show_b),
    .base_a(base_a), .base_b(base_b), .vcnt(vcnt), .base_we(base_we),
    .swap_req(swap_req), .rdata(host_rdata), .irq_q(irq)
  );
endmodule

// File: tb/page_flip_raster_test.sv
`timescale 1ns/1ps
module page_flip_raster_test;
  localparam int HA = 16, HT = 24, HS = 18, HW = 3;
  localparam int VA = 6, VT = 10, VS = 7, VW = 2;
  localparam int AW = 24, DW = 32;
  localparam int FR = HT * VT;
  localparam int EVP = (VA - 1) * HT + HT - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic irq, hsync_n, vsync_n, de;
  logic [AW-1:0] fetch_addr;

  int tests = 0, fails = 0, edges = 0;
  logic cap_we = 1'b0;
  logic [2:0] cap_addr = 3'd0;
  logic [DW-1:0] cap_data = '0;

  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_hold;
  bit m_sel, m_pend;
  bit [1:0] m_st, m_en;

  always #10 clk = ~clk;

  page_flip_raster #(
    .H_ACTIVE(HA), .H_TOTAL(HT), .H_SYNC_START(HS), .H_SYNC_LEN(HW),
    .V_ACTIVE(VA), .V_TOTAL(VT), .V_SYNC_START(VS), .V_SYNC_LEN(VW),
    .ADDR_W(AW), .DATA_W(DW), .LINE_SHIFT(6), .PIX_SHIFT(3)
  ) uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .fetch_addr(fetch_addr)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edges);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int v, input int h);
    return b + AW'(v * 64) + AW'(h / 8);
  endfunction

  always @(posedge clk) begin
    cap_we <= host_we;
    cap_addr <= host_addr;
    cap_data <= host_wdata;
    if (!rst) edges <= edges + 1;
  end

  // Cycle model: outputs after edge k describe counter position k-1 and state after edge k-1.
  always @(negedge clk) begin
    if (!rst && edges >= 1) begin
      int p, h, v;
      bit e_de, evt, lend, flipw;
      logic [AW-1:0] ea;
      logic [DW-1:0] er;
      p = edges - 1;
      h = p % HT;
      v = (p / HT) % VT;
      e_de = (h < HA) && (v < VA);
      if (e_de) ea = exp_addr(m_base[m_sel], v, h);
      else ea = m_hold;
      m_hold = ea;
      chk("R1 de", DW'(de), DW'(e_de));
      chk("R2 hsync_n", DW'(hsync_n), DW'(!(h >= HS && h < HS + HW)));
      chk("R2 vsync_n", DW'(vsync_n), DW'(!(v >= VS && v < VS + VW)));
      chk("R3 R5 fetch_addr", DW'(fetch_addr), DW'(ea));
      chk("R8 irq", DW'(irq), DW'(|(m_st & m_en)));
      case (cap_addr)
        3'd0: er = DW'(m_base[0]);
        3'd1: er = DW'(m_base[1]);
        3'd2: er = DW'(m_en);
        3'd3: er = DW'({m_sel, m_pend, m_st});
        3'd5: er = DW'(v);
        default: er = '0;
      endcase
      case (cap_addr)
        3'd0, 3'd1: chk("R4 base readback", host_rdata, er);
        3'd2: chk("R8 ctrl readback", host_rdata, er);
        3'd3: chk("R4 R6 R7 status", host_rdata, er);
        3'd5: chk("R9 scanline", host_rdata, er);
        default: chk("R9 unused addr", host_rdata, er);
      endcase
      evt = (p % FR) == EVP;
      lend = (h == HT - 1);
      flipw = cap_we && (cap_addr == 3'd4);
      if (evt && (m_pend || flipw)) begin
        m_sel = !m_sel;
        m_pend = 1'b0;
      end else if (flipw) m_pend = 1'b1;
      if (cap_we && cap_addr == 3'd3) m_st = m_st & ~cap_data[1:0];
      m_st = m_st | {lend, evt};
      if (cap_we && cap_addr == 3'd2) m_en = cap_data[1:0];
      if (cap_we && cap_addr == 3'd0) m_base[0] = cap_data[AW-1:0];
      if (cap_we && cap_addr == 3'd1) m_base[1] = cap_data[AW-1:0];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 3'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pos(input int target);
    while ((edges % FR) != target) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    m_base[0] = '0; m_base[1] = '0; m_hold = '0;
    m_sel = 0; m_pend = 0; m_st = 0; m_en = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 reset de", DW'(de), 0);
    chk("R10 reset hsync_n", DW'(hsync_n), 1);
    chk("R10 reset vsync_n", DW'(vsync_n), 1);
    chk("R10 reset fetch_addr", DW'(fetch_addr), 0);
    chk("R10 reset irq", DW'(irq), 0);
    chk("R10 reset rdata", host_rdata, 0);
    rst = 1'b0;
    host_addr = 3'd3;
    idle(3);
    // R4: program both bases, displayed one changes at once
    wr(3'd0, 32'h0001_0000);
    wr(3'd1, 32'h0008_0000);
    // R8/R7: vertical-blank interrupt enabled, then cleared
    wr(3'd2, 32'd1);
    idle(FR + 20);
    wr(3'd3, 32'd3);
    idle(5);
    // R5/R6: mid-frame request waits for retrace
    wait_pos(2 * HT + 5);
    wr(3'd4, 32'd0);
    host_addr = 3'd3;
    idle(2 * FR);
    // R5: request landing on the retrace edge applies at once
    wait_pos(EVP);
    wr(3'd4, 32'd0);
    host_addr = 3'd3;
    idle(10);
    // R5: request during blanking waits a full frame
    wr(3'd4, 32'd0);
    idle(FR + 30);
    // R8: line interrupt only, vertical disabled
    wr(3'd2, 32'd2);
    idle(HT * 3);
    wr(3'd3, 32'd2);
    idle(2);
    wr(3'd2, 32'd0);
    idle(HT * 2);
    host_addr = 3'd5;
    idle(FR);
    // Random phase
    for (int i = 0; i < 24000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 2) begin
        host_we = 1'b1; host_addr = 3'd4; host_wdata = $urandom;
      end else if (r < 9) begin
        host_we = 1'b1; host_addr = 3'($urandom % 4); host_wdata = $urandom;
      end else begin
        host_we = 1'b0; host_addr = 3'($urandom % 8); host_wdata = $urandom;
      end
      @(negedge clk);
    end
    host_we = 1'b0;
    idle(4);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule